// File: doc/BRIEF.md
# Command Acknowledgement Checker for a Byte-Serial Target Link

After a host has shifted a command header out to a serial target, the target answers with a stream of bytes that has to be interpreted before any further traffic is allowed. This block watches that received byte stream. It is told which opcode was issued and whether the link currently runs without CRC protection. It then asks for dummy byte reads (`rd_req`) until it can decide the outcome. Each run ends with a single-cycle result: `ok`, `fail` or `need_reset`.

The answer always starts with the target echoing the opcode, followed by a zero status byte. The block hunts for each of these over a bounded number of bytes. The three control opcodes add one leading filler byte, which is dropped before the hunt starts. Read opcodes add a data-start marker, recognised by its upper nibble being all ones, and the hunt for it is also bounded. Word reads then capture four bytes into a 32-bit value and swallow the trailing CRC bytes. A separate entry point checks the short acknowledgement that a target returns after the data phase of a block write.

Issuing commands, resending them and the reset-and-retry policy belong to the surrounding controller.

Top module: `cmd_ack_checker`

## Requirements
- R1: After reset, `rd_req`, `ok`, `fail` and `need_reset` are all low.
- R2: For the control opcodes 0xCF, 0xC5 and 0xC6, the first received byte is discarded unexamined before the echo hunt starts.
- R3: In the echo hunt, a byte equal to the issued opcode ends the hunt. Up to RETRY_LIMIT+1 bytes are examined. If the last of them also mismatches, `fail` is raised.
- R4: After the echo, the block hunts for a status byte of 0x00 under the same bound. If that bound is exhausted, `fail` is raised.
- R5: For any opcode other than the four reads (0xC4, 0xCA, 0xC2, 0xC8), the zero status byte completes the run with `ok`.
- R6: For read opcodes, the block next hunts for a byte whose bits 7:4 are 0xF. If RETRY_LIMIT consecutive bytes fail this test, `need_reset` is raised on the last of them.
- R7: For the word reads 0xC4 and 0xCA, the four bytes that follow the marker are assembled little-endian on `rdata`: the first byte lands in bits 7:0. `rdata` changes only while these bytes are taken.
- R8: After the four word bytes, two CRC bytes are consumed without checking when `crc_off` was low at start. When `crc_off` was high, `ok` follows the fourth word byte directly.
- R9: For the block reads 0xC2 and 0xC8, the data-start marker completes the run with `ok`.
- R10: A `dack_start` pulse checks a write-data acknowledgement of 2 bytes (CRC on) or 3 bytes (CRC off). The run ends with `ok` only if the final byte is 0x00 and the byte before it is 0xC3. Otherwise it ends with `fail`.
- R11: `rd_req` is high exactly while a run is in progress. `start` and `dack_start` are ignored while `rd_req` is high.
- R12: Every run ends with exactly one of `ok`, `fail` and `need_reset` high for one cycle. That cycle directly follows the edge that accepted the deciding byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin checking the answer to `opcode` |
| dack_start | input | 1 | Begin checking a write-data acknowledgement |
| opcode | input | 8 | Issued command opcode, sampled with `start` |
| crc_off | input | 1 | Link runs without CRC, sampled with either start |
| rx_valid | input | 1 | `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| rd_req | output | 1 | Request for further dummy byte reads |
| ok | output | 1 | Run completed successfully (one cycle) |
| fail | output | 1 | Run failed (one cycle) |
| need_reset | output | 1 | Data-start marker not found; link reset needed (one cycle) |
| rdata | output | 32 | Captured word from a word read |

## Verification
The bench builds the block with RETRY_LIMIT set to 4 and the word and CRC lengths left at 4 and 2. The short retry bound puts both edges of every hunt within a few bytes: the last byte that may still match, and the byte that exhausts the bound. The echo and status hunts can therefore be pushed to `fail`, and the marker hunt to `need_reset`, with short directed byte lists. The default lengths keep the byte ordering and CRC-skip checks on the real frame shape.

// File: rtl/cmdchk_pkg.sv
package cmdchk_pkg;
  localparam logic [7:0] OP_RESET    = 8'hCF;
  localparam logic [7:0] OP_TERM     = 8'hC5;
  localparam logic [7:0] OP_REPEAT   = 8'hC6;
  localparam logic [7:0] OP_INT_RD   = 8'hC4;
  localparam logic [7:0] OP_SGL_RD   = 8'hCA;
  localparam logic [7:0] OP_BLK_RD   = 8'hC2;
  localparam logic [7:0] OP_BLK_RDX  = 8'hC8;
  localparam logic [7:0] ACK_TAG     = 8'hC3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SKIP, PH_ECHO, PH_STATUS, PH_MARK, PH_WORD, PH_CRC, PH_DACK
  } phase_t;

  typedef struct packed {
    logic ctrl;
    logic word_rd;
    logic blk_rd;
  } op_class_t;
endpackage

// File: rtl/cmdchk_opclass.sv
module cmdchk_opclass
  import cmdchk_pkg::*;
(
  input  logic [7:0] op,
  output op_class_t  cls
);
  always_comb begin
    cls.ctrl    = (op == OP_RESET) || (op == OP_TERM) || (op == OP_REPEAT);
    cls.word_rd = (op == OP_INT_RD) || (op == OP_SGL_RD);
    cls.blk_rd  = (op == OP_BLK_RD) || (op == OP_BLK_RDX);
  end
endmodule

// File: rtl/cmdchk_tally.sv
module cmdchk_tally #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || inc) cnt <= cnt_d;
  end
endmodule

// File: rtl/cmdchk_word.sv
module cmdchk_word #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [7:0]         din,
  output logic [8*BYTES-1:0] word
);
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] lane_d;
    if (g == BYTES - 1) begin : g_top
      assign lane_d = din;
    end else begin : g_mid
      assign lane_d = word[8*(g+1) +: 8];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word[8*g +: 8] <= '0;
      else if (en) word[8*g +: 8] <= lane_d;
    end
  end
endmodule

// File: rtl/cmd_ack_checker.sv
module cmd_ack_checker
  import cmdchk_pkg::*;
#(
  parameter int RETRY_LIMIT = 10,
  parameter int WORD_BYTES  = 4,
  parameter int CRC_BYTES   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    dack_start,
  input  logic [7:0]              opcode,
  input  logic                    crc_off,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_byte,
  output logic                    rd_req,
  output logic                    ok,
  output logic                    fail,
  output logic                    need_reset,
  output logic [8*WORD_BYTES-1:0] rdata
);
  localparam int MW = $clog2(RETRY_LIMIT + 1) + 1;
  localparam int IW = $clog2(WORD_BYTES + CRC_BYTES + 4);
  localparam logic [MW-1:0] ECHO_LAST = MW'(RETRY_LIMIT);
  localparam logic [MW-1:0] MARK_LAST = MW'(RETRY_LIMIT - 1);
  localparam logic [IW-1:0] WORD_LAST = IW'(WORD_BYTES - 1);
  localparam logic [IW-1:0] CRC_LAST  = IW'(CRC_BYTES - 1);
  localparam logic [IW-1:0] DACK_LAST_ON  = IW'(1);
  localparam logic [IW-1:0] DACK_LAST_OFF = IW'(2);

  phase_t    phase_q, phase_d;
  op_class_t cls_in, cls_q;
  logic [7:0] op_q;
  logic       crc_off_q, bad_q, bad_set;
  logic       take, acc, miss_inc, idx_inc, ph_chg, shift_en;
  logic       ok_d, fail_d, nr_d;
  logic [MW-1:0] miss_cnt;
  logic [IW-1:0] idx_cnt, dack_last;

  cmdchk_opclass u_cls (.op(opcode), .cls(cls_in));

  cmdchk_tally #(.W(MW)) u_miss (
    .clk(clk), .rst_n(rst_n), .clr(ph_chg), .inc(miss_inc), .cnt(miss_cnt));

  cmdchk_tally #(.W(IW)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(ph_chg), .inc(idx_inc), .cnt(idx_cnt));

  cmdchk_word #(.BYTES(WORD_BYTES)) u_word (
    .clk(clk), .rst_n(rst_n), .en(shift_en), .din(rx_byte), .word(rdata));

  assign acc       = rx_valid && (phase_q != PH_IDLE);
  assign rd_req    = (phase_q != PH_IDLE);
  assign dack_last = crc_off_q ? DACK_LAST_OFF : DACK_LAST_ON;
  assign ph_chg    = (phase_d != phase_q);
  assign shift_en  = acc && (phase_q == PH_WORD);

  // next-state process
  always_comb begin
    phase_d  = phase_q;
    take     = 1'b0;
    miss_inc = 1'b0;
    idx_inc  = 1'b0;
    bad_set  = 1'b0;
    ok_d     = 1'b0;
    fail_d   = 1'b0;
    nr_d     = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          take    = 1'b1;
          phase_d = cls_in.ctrl ? PH_SKIP : PH_ECHO;
        end else if (dack_start) begin
          take    = 1'b1;
          phase_d = PH_DACK;
        end
      end
      PH_SKIP: if (acc) phase_d = PH_ECHO;
      PH_ECHO: if (acc) begin
        if (rx_byte == op_q)          phase_d = PH_STATUS;
        else if (miss_cnt == ECHO_LAST) begin fail_d = 1'b1; phase_d = PH_IDLE; end
        else                          miss_inc = 1'b1;
      end
      PH_STATUS: if (acc) begin
        if (rx_byte == 8'h00) begin
          if (cls_q.word_rd || cls_q.blk_rd) phase_d = PH_MARK;
          else begin ok_d = 1'b1; phase_d = PH_IDLE; end
        end else if (miss_cnt == ECHO_LAST) begin
          fail_d = 1'b1; phase_d = PH_IDLE;
        end else miss_inc = 1'b1;
      end
      PH_MARK: if (acc) begin
        if (rx_byte[7:4] == 4'hF) begin
          if (cls_q.word_rd) phase_d = PH_WORD;
          else begin ok_d = 1'b1; phase_d = PH_IDLE; end
        end else if (miss_cnt == MARK_LAST) begin
          nr_d = 1'b1; phase_d = PH_IDLE;
        end else miss_inc = 1'b1;
      end
      PH_WORD: if (acc) begin
        if (idx_cnt == WORD_LAST) begin
          if (crc_off_q) begin ok_d = 1'b1; phase_d = PH_IDLE; end
          else phase_d = PH_CRC;
        end else idx_inc = 1'b1;
      end
      PH_CRC: if (acc) begin
        if (idx_cnt == CRC_LAST) begin ok_d = 1'b1; phase_d = PH_IDLE; end
        else idx_inc = 1'b1;
      end
      PH_DACK: if (acc) begin
        if (idx_cnt == dack_last) begin
          if (!bad_q && rx_byte == 8'h00) ok_d = 1'b1;
          else fail_d = 1'b1;
          phase_d = PH_IDLE;
        end else begin
          idx_inc = 1'b1;
          if (idx_cnt == dack_last - 1'b1 && rx_byte != ACK_TAG) bad_set = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      ok         <= 1'b0;
      fail       <= 1'b0;
      need_reset <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      ok         <= ok_d;
      fail       <= fail_d;
      need_reset <= nr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= '0;
      cls_q     <= '0;
      crc_off_q <= 1'b0;
    end else if (take) begin
      op_q      <= opcode;
      cls_q     <= cls_in;
      crc_off_q <= crc_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            bad_q <= 1'b0;
    else if (take)         bad_q <= 1'b0;
    else if (bad_set)      bad_q <= 1'b1;
  end
endmodule

// File: rtl/cmd_ack_checker_sva.sv
module cmd_ack_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        rx_valid,
  input logic        rd_req,
  input logic        ok,
  input logic        fail,
  input logic        need_reset,
  input logic [31:0] rdata
);
  // R12: never more than one result flag
  p_one_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok, fail, need_reset}));

  // R11: a result means the run is over
  p_idle_at_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ok || fail || need_reset) |-> !rd_req);

  // R11: a start taken while idle opens a run
  p_start_opens_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !rd_req) |=> rd_req);

  // R7: captured word only moves during a run
  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rdata));

  // R12: a result is decided by an accepted byte
  p_result_on_byte_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ok || fail || need_reset) |-> ($past(rx_valid) && $past(rd_req)));
endmodule

bind cmd_ack_checker cmd_ack_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .rx_valid(rx_valid),
  .rd_req(rd_req), .ok(ok), .fail(fail), .need_reset(need_reset),
  .rdata(rdata));

// File: tb/cmd_ack_checker_tb.sv
module cmd_ack_checker_tb;
  localparam int RL = 4;

  logic clk = 1'b0;
  logic rst_n, start, dack_start, crc_off, rx_valid;
  logic [7:0] opcode, rx_byte;
  logic rd_req, ok, fail, need_reset;
  logic [31:0] rdata;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cmd_ack_checker #(.RETRY_LIMIT(RL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dack_start(dack_start),
    .opcode(opcode), .crc_off(crc_off), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rd_req(rd_req), .ok(ok), .fail(fail), .need_reset(need_reset), .rdata(rdata));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // result flags as {ok,fail,need_reset}
  task automatic res(input string tag, input logic [2:0] exp);
    chk(tag, {29'd0, ok, fail, need_reset}, {29'd0, exp});
  endtask

  task automatic go(input logic [7:0] op, input logic co);
    opcode = op; crc_off = co; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic go_dack(input logic co);
    crc_off = co; dack_start = 1'b1;
    @(negedge clk);
    dack_start = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rd_req", {31'd0, rd_req}, 32'd0);
    res("R1 flags", 3'b000);
  endtask

  task automatic t_write_ok;
    go(8'hC9, 1'b0);
    chk("R11 rd_req busy", {31'd0, rd_req}, 32'd1);
    rx(8'h11); rx(8'hC9); res("R3 no result after echo", 3'b000);
    rx(8'h00); res("R5 ok after status", 3'b100);
    chk("R11 rd_req idle", {31'd0, rd_req}, 32'd0);
    @(negedge clk); res("R12 single cycle", 3'b000);
  endtask

  task automatic t_ctrl_skip;
    go(8'hCF, 1'b0);
    rx(8'hCF); rx(8'h00); res("R2 first byte skipped", 3'b000);
    rx(8'hCF); rx(8'h00); res("R2 ok after skip", 3'b100);
  endtask

  task automatic t_echo_bound;
    go(8'hC9, 1'b0);
    for (int i = 0; i < RL; i++) rx(8'h55);
    res("R3 last echo try open", 3'b000);
    rx(8'hC9); rx(8'h00); res("R3 late echo ok", 3'b100);
    go(8'hC9, 1'b0);
    for (int i = 0; i < RL + 1; i++) rx(8'h55);
    res("R3 echo exhausted", 3'b010);
  endtask

  task automatic t_status_bound;
    go(8'hC9, 1'b0);
    rx(8'hC9);
    for (int i = 0; i < RL; i++) rx(8'h01);
    res("R4 status still open", 3'b000);
    rx(8'h02); res("R4 status exhausted", 3'b010);
  endtask

  task automatic t_word_read;
    go(8'hCA, 1'b0);
    rx(8'hCA); rx(8'h00); rx(8'h3F); rx(8'hF3);
    rx(8'h11); rx(8'h22); rx(8'h33); rx(8'h44);
    res("R8 waits for crc", 3'b000);
    rx(8'hAB); res("R8 crc byte one", 3'b000);
    rx(8'hCD); res("R8 ok after crc", 3'b100);
    chk("R7 little endian", rdata, 32'h44332211);
    go(8'hC4, 1'b1);
    rx(8'hC4); rx(8'h00); rx(8'hF0);
    rx(8'hA1); rx(8'hB2); rx(8'hC3); rx(8'hD4);
    res("R8 crc off ok", 3'b100);
    chk("R7 word crc off", rdata, 32'hD4C3B2A1);
    go(8'hC9, 1'b0);
    rx(8'hC9); rx(8'h00);
    chk("R7 word kept", rdata, 32'hD4C3B2A1);
  endtask

  task automatic t_mark_bound;
    go(8'hCA, 1'b0);
    rx(8'hCA); rx(8'h00);
    for (int i = 0; i < RL - 1; i++) rx(8'h0F);
    res("R6 marker still open", 3'b000);
    rx(8'hEF); res("R6 need reset", 3'b001);
  endtask

  task automatic t_block_read;
    go(8'hC8, 1'b0);
    rx(8'hC8); rx(8'h00); rx(8'hFF);
    res("R9 ok at marker", 3'b100);
  endtask

  task automatic t_dack;
    go_dack(1'b0); rx(8'hC3); rx(8'h00); res("R10 crc on good", 3'b100);
    go_dack(1'b0); rx(8'hC3); rx(8'h01); res("R10 bad last", 3'b010);
    go_dack(1'b0); rx(8'h00); rx(8'h00); res("R10 bad tag", 3'b010);
    go_dack(1'b1); rx(8'h77); rx(8'hC3); res("R10 crc off pending", 3'b000);
    rx(8'h00); res("R10 crc off good", 3'b100);
  endtask

  task automatic t_busy_start;
    go(8'hC9, 1'b0);
    go(8'hCA, 1'b0);
    rx(8'hC9); rx(8'h00); res("R11 start ignored busy", 3'b100);
  endtask

  initial begin
    rst_n = 1'b0; start = 0; dack_start = 0; crc_off = 0;
    rx_valid = 0; rx_byte = '0; opcode = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_ok();
    t_ctrl_skip();
    t_echo_bound();
    t_status_bound();
    t_word_read();
    t_mark_bound();
    t_block_read();
    t_dack();
    t_busy_start();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule